// File: doc/BRIEF.md
# Warp Issue Scheduler

This block is the issue stage of one processing slice in a parallel compute core. It holds a pool of resident warps, whose size is set by a parameter. Each cycle it decides which warps could issue and picks at most one of them. For every warp it also reports a state code: whether the warp issued, was ready but lost the pick, or why it could not issue. Decode, the register file and the execution pipes sit outside the block. The block sees only per-warp readiness flags and a busy bit for each function unit.

Residency is held inside the block. A one-cycle launch pulse makes a warp resident, and a one-cycle retire pulse removes it. The pick rotates through the eligible warps so that none of them starves. Four saturating statistics accumulators record the following: resident warps per cycle, eligible warps per cycle, issues, and skipped issue slots. A synchronous clear input zeroes all four.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset the pool is empty, the rotation pointer is at warp 0, all four accumulators read zero and `issue_valid` is low.
- R2: A `warp_launch` bit makes that warp resident from the next cycle on. A `warp_retire` bit removes it from the next cycle on. When both are set for the same warp in the same cycle, the launch wins.
- R3: A warp is eligible in a cycle only when all of the following hold: it is resident, `wp_decoded` is 1, `wp_deps_ok` is 1, and the busy bit of the unit named by its `wp_unit` field is 0. A unit ID at or above NUM_UNITS counts as busy.
- R4: In the same cycle, `issue_valid` is 1 exactly when at least one warp is eligible. `issue_warp` then names an eligible warp.
- R5: The search starts at the rotation pointer and goes upward with wrap-around. The first eligible warp found is picked. After an issue the pointer moves to the warp after the one that issued, wrapping at NUM_WARPS. With no issue the pointer holds.
- R6: The picked warp reports state 1 (selected). Every other eligible warp reports state 2 (ready but not picked).
- R7: A warp that is not resident reports state 0. For an ineligible resident warp the causes are checked in this order. First, `wp_decoded` low gives 3 (fetch wait). Next, `wp_deps_ok` low gives the code taken from its 2-bit `wp_wait_kind`: 0 gives 4 (memory dependency), 1 or 3 gives 5 (execution dependency), and 2 gives 6 (barrier wait). Last, a busy target unit gives 7 (pipe busy).
- R8: `n_active` and `n_eligible` give the number of resident warps and the number of eligible warps in the current cycle.
- R9: On each cycle without clear, the accumulators add the following, visible on the next cycle: `n_active`, `n_eligible`, one per issue, and one per cycle with no issue (skipped slot).
- R10: Each accumulator saturates at all ones and stays there until cleared.
- R11: `stats_clr` sets all four accumulators to zero on the next cycle, overriding that cycle's additions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stats_clr | input | 1 | Synchronous clear of the accumulators |
| warp_launch | input | NUM_WARPS | Per-warp pulse that makes a warp resident |
| warp_retire | input | NUM_WARPS | Per-warp pulse that removes a warp |
| wp_decoded | input | NUM_WARPS | Warp has a decoded instruction ready |
| wp_deps_ok | input | NUM_WARPS | All operands of the instruction are resolved |
| wp_wait_kind | input | 2*NUM_WARPS | Cause of an unresolved dependency, 2 bits per warp |
| wp_unit | input | NUM_WARPS*UNIT_W | Target function unit ID per warp |
| unit_busy | input | NUM_UNITS | Busy bit per function unit |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WARP_W | Index of the issuing warp |
| warp_state | output | 3*NUM_WARPS | State code per warp |
| n_active | output | CNT_N_W | Resident warps this cycle |
| n_eligible | output | CNT_N_W | Eligible warps this cycle |
| acc_active | output | ACC_W | Accumulated resident-warp count |
| acc_eligible | output | ACC_W | Accumulated eligible-warp count |
| acc_issued | output | ACC_W | Accumulated issues |
| acc_skipped | output | ACC_W | Accumulated skipped issue slots |

## Verification
The bench uses a four-warp, two-unit configuration with narrow accumulators. It sweeps readiness, wait kinds, unit targets and busy patterns, and checks every output against an arithmetic model each cycle. It drives long stretches in which every warp is eligible, to check the rotation. A scheduler that restarted the search at warp 0 would keep picking the lowest warps. A pointer with an off-by-one error would repeat or skip warps. The sweep also covers warps that are ready except for a busy unit. A design that ignored the unit check would issue to a busy pipe, or report the wrong cause in the stall priority. The accumulators are run into saturation, and clears are applied on the same cycle as additions. A counter that wraps would drop to a small value. A clear that loses to an addition would leave a nonzero count.

// File: rtl/wis_pkg.sv
package wis_pkg;

    typedef enum logic [2:0] {
        WS_EMPTY        = 3'd0,
        WS_SELECTED     = 3'd1,
        WS_NOT_SELECTED = 3'd2,
        WS_FETCH        = 3'd3,
        WS_MEMDEP       = 3'd4,
        WS_EXECDEP      = 3'd5,
        WS_BARRIER      = 3'd6,
        WS_PIPEBUSY     = 3'd7
    } wstate_e;

    typedef enum logic [1:0] {
        WK_MEM     = 2'd0,
        WK_EXEC    = 2'd1,
        WK_BARRIER = 2'd2,
        WK_RSVD    = 2'd3
    } wait_kind_e;

    localparam int STATE_W = 3;
    localparam int KIND_W  = 2;

    // Cause code for a warp that is resident but cannot issue.
    function automatic wstate_e stall_code(logic decoded, logic deps_ok,
                                           wait_kind_e kind);
        wstate_e s;
        if (!decoded)
            s = WS_FETCH;
        else if (!deps_ok) begin
            case (kind)
                WK_MEM:     s = WS_MEMDEP;
                WK_BARRIER: s = WS_BARRIER;
                default:    s = WS_EXECDEP;
            endcase
        end else
            s = WS_PIPEBUSY;
        return s;
    endfunction

endpackage

// File: rtl/wis_elig.sv
module wis_elig
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int NUM_UNITS = 4,
    parameter int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic [NUM_WARPS-1:0]          resident,
    input  logic [NUM_WARPS-1:0]          decoded,
    input  logic [NUM_WARPS-1:0]          deps_ok,
    input  logic [KIND_W*NUM_WARPS-1:0]   wait_kind,
    input  logic [NUM_WARPS*UNIT_W-1:0]   unit_id,
    input  logic [NUM_UNITS-1:0]          unit_busy,
    output logic [NUM_WARPS-1:0]          eligible,
    output logic [STATE_W*NUM_WARPS-1:0]  stall_state
);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic [UNIT_W-1:0] uid;
        logic              tgt_busy;
        wstate_e           st;

        assign uid = unit_id[w*UNIT_W +: UNIT_W];

        always_comb begin
            if (int'(uid) < NUM_UNITS)
                tgt_busy = unit_busy[uid];
            else
                tgt_busy = 1'b1;
        end

        assign eligible[w] = resident[w] & decoded[w] & deps_ok[w] & ~tgt_busy;

        always_comb begin
            if (!resident[w])
                st = WS_EMPTY;
            else if (eligible[w])
                st = WS_NOT_SELECTED;
            else
                st = stall_code(decoded[w], deps_ok[w],
                                wait_kind_e'(wait_kind[KIND_W*w +: KIND_W]));
        end

        assign stall_state[STATE_W*w +: STATE_W] = st;
    end

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int NUM_WARPS = 8,
    parameter int WARP_W    = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0] eligible,
    input  logic [WARP_W-1:0]    start,
    output logic                 found,
    output logic [WARP_W-1:0]    pick
);

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < NUM_WARPS; k++) begin
            logic [WARP_W:0] cand;
            cand = {1'b0, start} + (WARP_W+1)'(k);
            if (cand >= (WARP_W+1)'(NUM_WARPS))
                cand = cand - (WARP_W+1)'(NUM_WARPS);
            if (!found && eligible[cand[WARP_W-1:0]]) begin
                found = 1'b1;
                pick  = cand[WARP_W-1:0];
            end
        end
    end

endmodule

// File: rtl/wis_sat_acc.sv
module wis_sat_acc #(
    parameter int ACC_W = 32,
    parameter int ADD_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [ADD_W-1:0] add,
    output logic [ACC_W-1:0] acc
);

    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic [ACC_W:0] sum;
    assign sum = {1'b0, acc} + (ACC_W+1)'(add);

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc <= '0;
        else if (sum[ACC_W])
            acc <= ACC_MAX;
        else
            acc <= sum[ACC_W-1:0];
    end

    assert_saturate_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_MAX && !clr) |=> acc == ACC_MAX);

    assert_clear_zero_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> acc == '0);

    assert_monotone_R9: assert property (@(posedge clk) disable iff (rst)
        !clr |=> acc >= $past(acc));

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int NUM_UNITS = 4,
    parameter int ACC_W     = 32,
    parameter int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    parameter int WARP_W    = $clog2(NUM_WARPS),
    parameter int CNT_N_W   = $clog2(NUM_WARPS + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          stats_clr,
    input  logic [NUM_WARPS-1:0]          warp_launch,
    input  logic [NUM_WARPS-1:0]          warp_retire,
    input  logic [NUM_WARPS-1:0]          wp_decoded,
    input  logic [NUM_WARPS-1:0]          wp_deps_ok,
    input  logic [2*NUM_WARPS-1:0]        wp_wait_kind,
    input  logic [NUM_WARPS*UNIT_W-1:0]   wp_unit,
    input  logic [NUM_UNITS-1:0]          unit_busy,
    output logic                          issue_valid,
    output logic [WARP_W-1:0]             issue_warp,
    output logic [3*NUM_WARPS-1:0]        warp_state,
    output logic [CNT_N_W-1:0]            n_active,
    output logic [CNT_N_W-1:0]            n_eligible,
    output logic [ACC_W-1:0]              acc_active,
    output logic [ACC_W-1:0]              acc_eligible,
    output logic [ACC_W-1:0]              acc_issued,
    output logic [ACC_W-1:0]              acc_skipped
);

    logic [NUM_WARPS-1:0]         resident_q;
    logic [WARP_W-1:0]            rr_ptr_q;
    logic [NUM_WARPS-1:0]         elig;
    logic [STATE_W*NUM_WARPS-1:0] base_state;
    logic [NUM_WARPS-1:0]         sel_vec;

    // Pool of resident warps; a launch overrides a retire of the same warp.
    always_ff @(posedge clk) begin
        if (rst)
            resident_q <= '0;
        else
            resident_q <= (resident_q & ~warp_retire) | warp_launch;
    end

    wis_elig #(
        .NUM_WARPS (NUM_WARPS),
        .NUM_UNITS (NUM_UNITS),
        .UNIT_W    (UNIT_W)
    ) u_elig (
        .resident    (resident_q),
        .decoded     (wp_decoded),
        .deps_ok     (wp_deps_ok),
        .wait_kind   (wp_wait_kind),
        .unit_id     (wp_unit),
        .unit_busy   (unit_busy),
        .eligible    (elig),
        .stall_state (base_state)
    );

    wis_rr_pick #(
        .NUM_WARPS (NUM_WARPS),
        .WARP_W    (WARP_W)
    ) u_pick (
        .eligible (elig),
        .start    (rr_ptr_q),
        .found    (issue_valid),
        .pick     (issue_warp)
    );

    // Rotation pointer moves one past the issuing warp.
    always_ff @(posedge clk) begin
        if (rst)
            rr_ptr_q <= '0;
        else if (issue_valid) begin
            if (int'(issue_warp) == NUM_WARPS - 1)
                rr_ptr_q <= '0;
            else
                rr_ptr_q <= issue_warp + WARP_W'(1);
        end
    end

    // Merge the pick into the per-warp state codes.
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_state
        assign sel_vec[w] = issue_valid && (int'(issue_warp) == w);
        assign warp_state[3*w +: 3] = sel_vec[w] ? 3'(WS_SELECTED)
                                                 : base_state[STATE_W*w +: STATE_W];
    end

    always_comb begin
        n_active   = '0;
        n_eligible = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            n_active   = n_active   + CNT_N_W'(resident_q[w]);
            n_eligible = n_eligible + CNT_N_W'(elig[w]);
        end
    end

    wis_sat_acc #(.ACC_W(ACC_W), .ADD_W(CNT_N_W)) u_acc_active (
        .clk(clk), .rst(rst), .clr(stats_clr), .add(n_active), .acc(acc_active));

    wis_sat_acc #(.ACC_W(ACC_W), .ADD_W(CNT_N_W)) u_acc_elig (
        .clk(clk), .rst(rst), .clr(stats_clr), .add(n_eligible), .acc(acc_eligible));

    wis_sat_acc #(.ACC_W(ACC_W), .ADD_W(1)) u_acc_issue (
        .clk(clk), .rst(rst), .clr(stats_clr), .add(issue_valid), .acc(acc_issued));

    wis_sat_acc #(.ACC_W(ACC_W), .ADD_W(1)) u_acc_skip (
        .clk(clk), .rst(rst), .clr(stats_clr), .add(!issue_valid), .acc(acc_skipped));

    assert_issue_only_eligible_R4: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> elig[issue_warp]);

    assert_no_idle_when_ready_R4: assert property (@(posedge clk) disable iff (rst)
        (|elig) |-> issue_valid);

    assert_single_selected_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_vec));

    assert_launch_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (|warp_launch) |=> ((resident_q & $past(warp_launch)) == $past(warp_launch)));

    assert_reset_clears_pool_R1: assert property (@(posedge clk)
        rst |=> (resident_q == '0 && rr_ptr_q == '0));

endmodule

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb_top;

    localparam int NW  = 4;
    localparam int NU  = 2;
    localparam int UW  = 1;
    localparam int AW  = 8;
    localparam int WW  = 2;
    localparam int CNW = 3;
    localparam int AMAX = (1 << AW) - 1;

    logic              clk = 1'b0;
    logic              rst;
    logic              stats_clr;
    logic [NW-1:0]     warp_launch, warp_retire, wp_decoded, wp_deps_ok;
    logic [2*NW-1:0]   wp_wait_kind;
    logic [NW*UW-1:0]  wp_unit;
    logic [NU-1:0]     unit_busy;
    logic              issue_valid;
    logic [WW-1:0]     issue_warp;
    logic [3*NW-1:0]   warp_state;
    logic [CNW-1:0]    n_active, n_eligible;
    logic [AW-1:0]     acc_active, acc_eligible, acc_issued, acc_skipped;

    always #4 clk = ~clk;

    warp_issue_sched #(
        .NUM_WARPS(NW), .NUM_UNITS(NU), .ACC_W(AW)
    ) dut_i (
        .clk(clk), .rst(rst), .stats_clr(stats_clr),
        .warp_launch(warp_launch), .warp_retire(warp_retire),
        .wp_decoded(wp_decoded), .wp_deps_ok(wp_deps_ok),
        .wp_wait_kind(wp_wait_kind), .wp_unit(wp_unit), .unit_busy(unit_busy),
        .issue_valid(issue_valid), .issue_warp(issue_warp),
        .warp_state(warp_state), .n_active(n_active), .n_eligible(n_eligible),
        .acc_active(acc_active), .acc_eligible(acc_eligible),
        .acc_issued(acc_issued), .acc_skipped(acc_skipped)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model state
    bit m_res [NW];
    int m_ptr;
    int m_acc_act, m_acc_elg, m_acc_iss, m_acc_skp;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat(int v);
        return (v > AMAX) ? AMAX : v;
    endfunction

    task automatic drive_idle();
        stats_clr = 0; warp_launch = '0; warp_retire = '0;
        wp_decoded = '0; wp_deps_ok = '0; wp_wait_kind = '0;
        wp_unit = '0; unit_busy = '0;
    endtask

    // Compare all outputs against the model, then advance the model.
    task automatic check_and_advance();
        bit elig [NW];
        int ne, na, pick, code;
        bit found;
        ne = 0; na = 0; found = 0; pick = 0;
        for (int w = 0; w < NW; w++) begin
            elig[w] = m_res[w] && wp_decoded[w] && wp_deps_ok[w] && !unit_busy[wp_unit[w]];
            if (m_res[w]) na++;
            if (elig[w]) ne++;
        end
        for (int k = 0; k < NW; k++) begin
            int c;
            c = (m_ptr + k) % NW;
            if (!found && elig[c]) begin found = 1; pick = c; end
        end
        chk("R3/R4 issue_valid", int'(issue_valid), int'(found));
        if (found) chk("R5 issue_warp", int'(issue_warp), pick);
        for (int w = 0; w < NW; w++) begin
            if (!m_res[w]) code = 0;
            else if (elig[w]) code = (found && pick == w) ? 1 : 2;
            else if (!wp_decoded[w]) code = 3;
            else if (!wp_deps_ok[w]) begin
                case (wp_wait_kind[2*w +: 2])
                    2'd0: code = 4;
                    2'd2: code = 6;
                    default: code = 5;
                endcase
            end else code = 7;
            chk((code == 1 || code == 2) ? "R6 state" : "R7 state",
                int'(warp_state[3*w +: 3]), code);
        end
        chk("R8 n_active", int'(n_active), na);
        chk("R8 n_eligible", int'(n_eligible), ne);
        chk("R9/R10 acc_active", int'(acc_active), m_acc_act);
        chk("R9/R10 acc_eligible", int'(acc_eligible), m_acc_elg);
        chk("R9/R10 acc_issued", int'(acc_issued), m_acc_iss);
        chk("R9/R10 acc_skipped", int'(acc_skipped), m_acc_skp);
        // advance model (R2, R5, R9, R11)
        if (stats_clr) begin
            m_acc_act = 0; m_acc_elg = 0; m_acc_iss = 0; m_acc_skp = 0;
        end else begin
            m_acc_act = sat(m_acc_act + na);
            m_acc_elg = sat(m_acc_elg + ne);
            m_acc_iss = sat(m_acc_iss + (found ? 1 : 0));
            m_acc_skp = sat(m_acc_skp + (found ? 0 : 1));
        end
        if (found) m_ptr = (pick + 1) % NW;
        for (int w = 0; w < NW; w++)
            m_res[w] = warp_launch[w] ? 1'b1 : (warp_retire[w] ? 1'b0 : m_res[w]);
    endtask

    task automatic run_phase(int cycles, int ready_bias, int churn, int clr_every);
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            for (int w = 0; w < NW; w++) begin
                warp_launch[w] = ($urandom_range(0, churn) == 0);
                warp_retire[w] = ($urandom_range(0, churn) == 0);
                wp_decoded[w]  = ($urandom_range(0, 7) < ready_bias);
                wp_deps_ok[w]  = ($urandom_range(0, 7) < ready_bias);
                wp_wait_kind[2*w +: 2] = 2'($urandom_range(0, 3));
                wp_unit[w]     = 1'($urandom_range(0, 1));
            end
            unit_busy = (ready_bias >= 8) ? '0 : NU'($urandom_range(0, 3));
            stats_clr = (clr_every > 0) && (n % clr_every == clr_every - 1);
            #2;
            check_and_advance();
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        drive_idle();
        rst = 1;
        for (int w = 0; w < NW; w++) m_res[w] = 0;
        m_ptr = 0; m_acc_act = 0; m_acc_elg = 0; m_acc_iss = 0; m_acc_skp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        // R1: reset state, pool empty and counters zero
        chk("R1 issue_valid", int'(issue_valid), 0);
        chk("R1 n_active", int'(n_active), 0);
        chk("R1 acc_skipped", int'(acc_skipped), 0);
        chk("R1 warp_state", int'(warp_state), 0);
        check_and_advance();
        // R2: launch and retire of the same warp in one cycle, launch wins
        @(negedge clk);
        warp_launch = 4'b0101; warp_retire = 4'b0111;
        #2; check_and_advance();
        @(negedge clk);
        drive_idle();
        #2;
        chk("R2 launch wins", int'(n_active), 2);
        check_and_advance();
        // R5: all warps launched and ready, rotation must visit every warp
        @(negedge clk);
        warp_launch = '1;
        #2; check_and_advance();
        for (int n = 0; n < 3 * NW; n++) begin
            @(negedge clk);
            warp_launch = '0; wp_decoded = '1; wp_deps_ok = '1; unit_busy = '0;
            #2;
            chk("R5 rotation order", int'(issue_warp), m_ptr);
            check_and_advance();
        end
        // Sweeps: mixed readiness, full readiness, sparse readiness; R10/R11 via clears
        run_phase(1500, 5, 8, 400);
        run_phase(800, 8, 30, 0);
        run_phase(1500, 3, 4, 97);
        run_phase(600, 6, 6, 1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule